// File: doc/BRIEF.md
# Read/Write Start Arbiter

This block sits in front of a memory core that has one read port and one write port sharing a single start slot. On each rising edge of the main clock it decides which of the two port selects may begin an access. Only one access may begin per cycle, and neither kind may begin on two cycles in a row, because every access occupies the core for two cycles.

Priority is neither fixed nor round-robin. It depends on what began in the cycle just before. A port that began last cycle loses to the other port, and an idle history favours the read. As a result, when both selects are held active from an idle state, the starts alternate, beginning with a read. The block drives one start pulse per port and exposes the previous-start record so that downstream logic can follow the sequence.

The start pulses are combinational from the present selects and the stored history, so they are valid for the edge on which the selects are sampled. The history register takes the decision at that edge.

Top module: `rw_start_arbiter`

## Requirements
- R1: `rd_start` and `wr_start` are never high in the same cycle.
- R2: While reset is asserted, and in the first cycle after it is released, `last_start` reads 2'b00 (idle).
- R3: With both selects high and `last_start` = 2'b00, `rd_start` is high and `wr_start` is low.
- R4: With both selects high and `last_start` = 2'b01 (read began last cycle), `wr_start` is high and `rd_start` is low.
- R5: With both selects high and `last_start` = 2'b10 (write began last cycle), `rd_start` is high and `wr_start` is low.
- R6: A read select in the cycle right after a read start is dropped: when `last_start` = 2'b01, `rd_start` stays low.
- R7: A write select in the cycle right after a write start is dropped: when `last_start` = 2'b10, `wr_start` stays low.
- R8: A lone active select starts its own port whenever that port did not start in the previous cycle.
- R9: `last_start` is updated on every rising edge: 2'b01 after a read start, 2'b10 after a write start, and 2'b00 after a cycle with no start. The value 2'b11 never appears.
- R10: Holding both selects high from an idle history gives starts in the order read, write, read, write.
- R11: With both selects low, no start pulse is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock; decisions take effect on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the history |
| rd_sel | input | 1 | Read port requests a start |
| wr_sel | input | 1 | Write port requests a start |
| rd_start | output | 1 | Read access begins at the coming edge |
| wr_start | output | 1 | Write access begins at the coming edge |
| last_start | output | 2 | Start taken at the previous edge: 00 idle, 01 read, 10 write |

## Verification
The start pulses depend combinationally on the selects and the stored history, so they are due in the same cycle as the stimulus. The bench changes the selects on the falling edge and samples a couple of nanoseconds later, before the rising edge that would act on them. The history is due one rising edge after the decision. Each vector checks the `last_start` left by the previous vector in the same sample window, so every result is compared exactly one edge after the decision that produced it.

// File: rtl/rw_start_arbiter.sv
module rw_start_arbiter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_sel,
  input  logic       wr_sel,
  output logic       rd_start,
  output logic       wr_start,
  output logic [1:0] last_start
);

  typedef enum logic [1:0] {
    HIST_IDLE  = 2'b00,
    HIST_READ  = 2'b01,
    HIST_WRITE = 2'b10
  } hist_e;

  hist_e hist_q;
  hist_e hist_d;

  logic rd_eligible;
  logic wr_eligible;

  assign rd_eligible = rd_sel && (hist_q != HIST_READ);
  assign wr_eligible = wr_sel && (hist_q != HIST_WRITE);

  // A conflict can only remain when the history is idle; the read wins there.
  assign rd_start = rd_eligible;
  assign wr_start = wr_eligible && !rd_eligible;

  always_comb begin
    if (rd_start)      hist_d = HIST_READ;
    else if (wr_start) hist_d = HIST_WRITE;
    else               hist_d = HIST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hist_q <= HIST_IDLE;
    else        hist_q <= hist_d;
  end

  assign last_start = hist_q;

endmodule

// File: rtl/rw_start_arbiter_chk.sv
module rw_start_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_sel,
  input logic       wr_sel,
  input logic       rd_start,
  input logic       wr_start,
  input logic [1:0] last_start
);

  p_single_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_start && wr_start));

  p_idle_after_reset_r2: assert property (@(posedge clk)
    !rst_n |=> last_start == 2'b00);

  p_idle_tie_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel && wr_sel && last_start == 2'b00) |-> rd_start);

  p_after_read_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel && wr_sel && last_start == 2'b01) |-> wr_start);

  p_after_write_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel && wr_sel && last_start == 2'b10) |-> rd_start);

  p_no_read_twice_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (last_start == 2'b01) |-> !rd_start);

  p_no_write_twice_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (last_start == 2'b10) |-> !wr_start);

  p_hist_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> last_start == 2'b01);

  p_hist_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> last_start == 2'b10);

  p_hist_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_start && !wr_start) |=> last_start == 2'b00);

  p_hist_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    last_start != 2'b11);

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_sel && !wr_sel) |-> (!rd_start && !wr_start));

endmodule

bind rw_start_arbiter rw_start_arbiter_chk u_chk (.*);

// File: tb/rw_start_arbiter_bench.sv
module rw_start_arbiter_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rd_sel;
  logic       wr_sel;
  logic       rd_start;
  logic       wr_start;
  logic [1:0] last_start;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  rw_start_arbiter u_rw_start_arbiter (
    .clk(clk), .rst_n(rst_n), .rd_sel(rd_sel), .wr_sel(wr_sel),
    .rd_start(rd_start), .wr_start(wr_start), .last_start(last_start)
  );

  // {req[3:0], rd_sel, wr_sel, exp_rd, exp_wr, exp_last[1:0]}
  localparam int NV = 17;
  localparam logic [9:0] VEC [NV] = '{
    {4'd11, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00},  // R11
    {4'd3,  1'b1, 1'b1, 1'b1, 1'b0, 2'b00},  // R3
    {4'd4,  1'b1, 1'b1, 1'b0, 1'b1, 2'b01},  // R4
    {4'd5,  1'b1, 1'b1, 1'b1, 1'b0, 2'b10},  // R5
    {4'd6,  1'b1, 1'b0, 1'b0, 1'b0, 2'b01},  // R6
    {4'd8,  1'b1, 1'b0, 1'b1, 1'b0, 2'b00},  // R8
    {4'd8,  1'b0, 1'b1, 1'b0, 1'b1, 2'b01},  // R8
    {4'd7,  1'b0, 1'b1, 1'b0, 1'b0, 2'b10},  // R7
    {4'd8,  1'b0, 1'b1, 1'b0, 1'b1, 2'b00},  // R8
    {4'd8,  1'b1, 1'b0, 1'b1, 1'b0, 2'b10},  // R8
    {4'd11, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01},  // R11
    {4'd10, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00},  // R10
    {4'd10, 1'b1, 1'b1, 1'b0, 1'b1, 2'b01},  // R10
    {4'd10, 1'b1, 1'b1, 1'b1, 1'b0, 2'b10},  // R10
    {4'd10, 1'b1, 1'b1, 1'b0, 1'b1, 2'b01},  // R10
    {4'd9,  1'b0, 1'b0, 1'b0, 1'b0, 2'b10},  // R9
    {4'd9,  1'b0, 1'b0, 1'b0, 1'b0, 2'b00}   // R9
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {rd,wr,last}=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic apply(input logic r, input logic w);
    @(negedge clk);
    rd_sel = r;
    wr_sel = w;
    #2;
  endtask

  initial begin
    rst_n = 1'b0; rd_sel = 1'b0; wr_sel = 1'b0;
    repeat (3) @(negedge clk);
    #2 check("R2", {rd_start & 1'b0, 1'b0, last_start}, 4'b0000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][5], VEC[i][4]);
      check($sformatf("R%0d", VEC[i][9:6]),
            {rd_start, wr_start, last_start}, VEC[i][3:0]);
      check("R1", {2'b00, 1'b0, rd_start & wr_start}, 4'b0000);
    end

    // R2: reset after a read start returns to idle; tie then favours read
    apply(1'b1, 1'b0);
    check("R8", {rd_start, wr_start, last_start}, 4'b1000);
    @(negedge clk);
    rst_n = 1'b0; rd_sel = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #2 check("R2", {rd_start, wr_start, last_start}, 4'b0000);
    apply(1'b1, 1'b1);
    check("R3", {rd_start, wr_start, last_start}, 4'b1000);
    apply(1'b1, 1'b1);
    check("R4", {rd_start, wr_start, last_start}, 4'b0101);

    // R2: reset after a write start also clears the history
    @(negedge clk);
    rst_n = 1'b0; rd_sel = 1'b0; wr_sel = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #2 check("R2", {rd_start, wr_start, last_start}, 4'b0000);

    // R7 and R8: write alone, repeated write dropped, then write again
    apply(1'b0, 1'b1);
    check("R8", {rd_start, wr_start, last_start}, 4'b0100);
    apply(1'b0, 1'b1);
    check("R7", {rd_start, wr_start, last_start}, 4'b0010);
    apply(1'b1, 1'b1);
    check("R3", {rd_start, wr_start, last_start}, 4'b1000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule